// File: doc/BRIEF.md
# Output Voltage Fault and Power-Good Supervisor

This block watches the feedback voltage of a step-down regulator. The voltage arrives as an unsigned code in millivolts, one sample per accepted transfer. From these samples the block drives an active-high power-good flag. It also latches overvoltage and undervoltage faults, and each fault overrides the gate-enable outputs that go to the switching stage. The reference point is 800 mV. Power-good uses a window of ±10% around it, and both edges of that window have hysteresis. After the feedback enters the window and stays there for a programmable number of clock cycles, power-good rises.

Samples arrive on a valid/ready input. The block never applies back-pressure: `fb_ready` is high whenever power-on reset is released, so every cycle with `fb_valid` high is a transfer. All threshold comparisons happen only on transfer cycles. In cycles without a transfer, the window and fault state are left as they are. An overvoltage fault stays latched until power-on reset. While it is latched, the high side is held off and the low side works as a crowbar with its own 400 mV / 1000 mV hysteresis. An undervoltage fault can only latch once soft-start has finished. It turns both gates off, and asserting the disable input clears it. When both faults are latched, the overvoltage fault sets the gate outputs.

Top module: `vout_supervisor`

## Requirements
- R1: While `por_n` is low and in the first cycle after it is released, `pgood`, `ov_flt`, `uv_flt` and `ls_force` are 0.
- R2: The feedback counts as inside the power-good window if it is at least 720 and at most 880 (both inclusive). Once inside, a transfer above 880 or below 720 takes it out, and `pgood` falls after that clock edge.
- R3: Once outside, the feedback comes back into the window only on a transfer in the range 736 to 864 inclusive. A transfer between 720 and 735, or between 865 and 880, leaves it outside.
- R4: `pgood` rises exactly QUAL_CYC clock edges after the first cycle in which the feedback is inside the window, `ss_done` is 1, `dis` is 0 and no fault is latched. If any of these conditions fails, the count restarts.
- R5: `pgood` is 0 whenever `ss_done` is 0, `dis` is 1, `ov_flt` is 1 or `uv_flt` is 1.
- R6: A transfer above 1000 sets `ov_flt` at that clock edge. `ov_flt` then stays set until `por_n` goes low, whatever `dis` does.
- R7: While `ov_flt` is 1, `hs_en` is 0. `ls_force` and `ls_en` follow a latch: a transfer above 1000 sets it, a transfer below 400 clears it, and any value from 400 to 1000 leaves it unchanged.
- R8: A transfer below 600 sets `uv_flt` only when `ss_done` is 1 and `dis` is 0 in that cycle. While `ss_done` is 0, such a transfer has no effect.
- R9: While `uv_flt` is 1 and `ov_flt` is 0, `hs_en`, `ls_en` and `ls_force` are all 0.
- R10: A cycle with `dis` high clears `uv_flt` at that edge. With no fault latched, `dis` high holds `hs_en` and `ls_en` at 0.
- R11: When `ov_flt` and `uv_flt` are both 1, the gate outputs follow R7.
- R12: A cycle with `fb_valid` low changes neither the fault flags, the window state nor the low-side crowbar latch, whatever value `fb_mv` carries.
- R13: `fb_ready` is 1 whenever `por_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| fb_mv | input | FB_W | Feedback voltage code in millivolts |
| fb_valid | input | 1 | Feedback sample offered |
| fb_ready | output | 1 | Sample accepted (high out of reset) |
| ss_done | input | 1 | Soft-start has completed |
| dis | input | 1 | Converter disable, active high |
| pgood | output | 1 | Power-good, active high |
| ov_flt | output | 1 | Overvoltage fault latched |
| uv_flt | output | 1 | Undervoltage fault latched |
| hs_en | output | 1 | High-side gate may switch |
| ls_en | output | 1 | Low-side gate may be on |
| ls_force | output | 1 | Low-side gate forced on (overvoltage crowbar) |

## Verification
The assertions assume that `ss_done` and `dis` change only between clock edges. They also assume that `fb_mv` is meaningful only in cycles where `fb_valid` is high. The undervoltage-origin property relies on the fault never latching while `ss_done` is low or `dis` is high. The bench changes every input on the falling clock edge. It places feedback codes exactly on each threshold and one code either side of it. On some cycles it drives out-of-range codes with `fb_valid` low, which shows that only accepted samples move the state.

// File: rtl/vout_sup_pkg.sv
package vout_sup_pkg;
  localparam int unsigned DEF_FB_W      = 11;
  localparam int unsigned DEF_PG_HI_MV  = 880;
  localparam int unsigned DEF_PG_LO_MV  = 720;
  localparam int unsigned DEF_PG_HYS_MV = 16;
  localparam int unsigned DEF_OV_MV     = 1000;
  localparam int unsigned DEF_OV_REL_MV = 400;
  localparam int unsigned DEF_UV_MV     = 600;
  localparam int unsigned DEF_QUAL_CYC  = 100;

  typedef struct packed {
    logic hs_en;
    logic ls_en;
    logic ls_force;
  } gate_ctl_t;
endpackage

// File: rtl/vs_pg_window.sv
module vs_pg_window #(
  parameter int unsigned FB_W   = 11,
  parameter int unsigned HI_MV  = 880,
  parameter int unsigned LO_MV  = 720,
  parameter int unsigned HYS_MV = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            fb_take,
  output logic            in_win
);
  localparam logic [FB_W-1:0] HI_C   = FB_W'(HI_MV);
  localparam logic [FB_W-1:0] LO_C   = FB_W'(LO_MV);
  localparam logic [FB_W-1:0] HI_IN  = FB_W'(HI_MV - HYS_MV);
  localparam logic [FB_W-1:0] LO_IN  = FB_W'(LO_MV + HYS_MV);

  logic leave_w, enter_w;

  always_comb begin
    leave_w = (fb_mv > HI_C) || (fb_mv < LO_C);
    enter_w = (fb_mv <= HI_IN) && (fb_mv >= LO_IN);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      in_win <= 1'b0;
    end else if (fb_take) begin
      if (in_win) in_win <= !leave_w;
      else        in_win <= enter_w;
    end
  end
endmodule

// File: rtl/vs_fault_latch.sv
module vs_fault_latch #(
  parameter int unsigned FB_W      = 11,
  parameter int unsigned OV_MV     = 1000,
  parameter int unsigned OV_REL_MV = 400,
  parameter int unsigned UV_MV     = 600
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            fb_take,
  input  logic            ss_done,
  input  logic            dis,
  output logic            ov_q,
  output logic            uv_q,
  output logic            crowbar_q
);
  localparam logic [FB_W-1:0] OV_C  = FB_W'(OV_MV);
  localparam logic [FB_W-1:0] REL_C = FB_W'(OV_REL_MV);
  localparam logic [FB_W-1:0] UV_C  = FB_W'(UV_MV);

  logic over_w, rel_w, under_w;

  always_comb begin
    over_w  = fb_take && (fb_mv > OV_C);
    rel_w   = fb_take && (fb_mv < REL_C);
    under_w = fb_take && (fb_mv < UV_C) && ss_done;
  end

  // overvoltage: sticky until power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      ov_q <= 1'b0;
    else if (over_w) ov_q <= 1'b1;
  end

  // crowbar hysteresis between release and trip levels
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      crowbar_q <= 1'b0;
    else if (over_w) crowbar_q <= 1'b1;
    else if (rel_w)  crowbar_q <= 1'b0;
  end

  // undervoltage: armed after soft-start, cleared by disable
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       uv_q <= 1'b0;
    else if (dis)     uv_q <= 1'b0;
    else if (under_w) uv_q <= 1'b1;
  end
endmodule

// File: rtl/vs_pg_qual.sv
module vs_pg_qual #(
  parameter int unsigned QUAL_CYC = 100
) (
  input  logic clk,
  input  logic por_n,
  input  logic cond_ok,
  output logic pg_out
);
  generate
    if (QUAL_CYC == 0) begin : g_direct
      assign pg_out = cond_ok;
    end else begin : g_count
      localparam int unsigned CW = $clog2(QUAL_CYC + 1);
      localparam logic [CW-1:0] LIM = CW'(QUAL_CYC);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cnt_q <= '0;
        else if (!cond_ok)   cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      end

      assign pg_out = cond_ok && (cnt_q == LIM);
    end
  endgenerate
endmodule

// File: rtl/vout_supervisor.sv
module vout_supervisor
  import vout_sup_pkg::*;
#(
  parameter int unsigned FB_W      = DEF_FB_W,
  parameter int unsigned PG_HI_MV  = DEF_PG_HI_MV,
  parameter int unsigned PG_LO_MV  = DEF_PG_LO_MV,
  parameter int unsigned PG_HYS_MV = DEF_PG_HYS_MV,
  parameter int unsigned OV_MV     = DEF_OV_MV,
  parameter int unsigned OV_REL_MV = DEF_OV_REL_MV,
  parameter int unsigned UV_MV     = DEF_UV_MV,
  parameter int unsigned QUAL_CYC  = DEF_QUAL_CYC
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            fb_valid,
  output logic            fb_ready,
  input  logic            ss_done,
  input  logic            dis,
  output logic            pgood,
  output logic            ov_flt,
  output logic            uv_flt,
  output logic            hs_en,
  output logic            ls_en,
  output logic            ls_force
);
  logic      take_w, in_win, ov_q, uv_q, crowbar_q, ok_w;
  gate_ctl_t gate_w;

  assign fb_ready = por_n;
  assign take_w   = fb_valid && fb_ready;

  vs_pg_window #(
    .FB_W(FB_W), .HI_MV(PG_HI_MV), .LO_MV(PG_LO_MV), .HYS_MV(PG_HYS_MV)
  ) u_win (
    .clk(clk), .por_n(por_n), .fb_mv(fb_mv), .fb_take(take_w), .in_win(in_win)
  );

  vs_fault_latch #(
    .FB_W(FB_W), .OV_MV(OV_MV), .OV_REL_MV(OV_REL_MV), .UV_MV(UV_MV)
  ) u_flt (
    .clk(clk), .por_n(por_n), .fb_mv(fb_mv), .fb_take(take_w),
    .ss_done(ss_done), .dis(dis),
    .ov_q(ov_q), .uv_q(uv_q), .crowbar_q(crowbar_q)
  );

  assign ok_w = in_win && ss_done && !dis && !ov_q && !uv_q;

  vs_pg_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .por_n(por_n), .cond_ok(ok_w), .pg_out(pgood)
  );

  // overvoltage outranks undervoltage, which outranks disable
  always_comb begin
    if (ov_q) begin
      gate_w.hs_en    = 1'b0;
      gate_w.ls_en    = crowbar_q;
      gate_w.ls_force = crowbar_q;
    end else if (uv_q || dis) begin
      gate_w = '0;
    end else begin
      gate_w.hs_en    = 1'b1;
      gate_w.ls_en    = 1'b1;
      gate_w.ls_force = 1'b0;
    end
  end

  assign hs_en    = gate_w.hs_en;
  assign ls_en    = gate_w.ls_en;
  assign ls_force = gate_w.ls_force;
  assign ov_flt   = ov_q;
  assign uv_flt   = uv_q;
endmodule

// File: rtl/vout_supervisor_chk.sv
module vout_supervisor_chk (
  input logic clk,
  input logic por_n,
  input logic fb_valid,
  input logic fb_ready,
  input logic ss_done,
  input logic dis,
  input logic pgood,
  input logic ov_flt,
  input logic uv_flt,
  input logic hs_en,
  input logic ls_en,
  input logic ls_force
);
  // R6
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    ov_flt |=> ov_flt);

  // R7
  ov_hs_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    ov_flt |-> !hs_en);

  // R5
  pg_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ov_flt || uv_flt || !ss_done || dis) |-> !pgood);

  // R8
  uv_origin_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(uv_flt) |-> $past(ss_done && fb_valid && !dis));

  // R9
  uv_gates_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    (uv_flt && !ov_flt) |-> (!hs_en && !ls_en && !ls_force));

  // R10
  uv_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    dis |=> !uv_flt);

  // R12
  no_take_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!fb_valid && !dis) |=> ($stable(ov_flt) && $stable(uv_flt)));

  // R13
  ready_up_chk: assert property (@(posedge clk) disable iff (!por_n)
    fb_ready);
endmodule

bind vout_supervisor vout_supervisor_chk u_chk (
  .clk(clk), .por_n(por_n), .fb_valid(fb_valid), .fb_ready(fb_ready),
  .ss_done(ss_done), .dis(dis), .pgood(pgood), .ov_flt(ov_flt),
  .uv_flt(uv_flt), .hs_en(hs_en), .ls_en(ls_en), .ls_force(ls_force)
);

// File: tb/vout_supervisor_tb_top.sv
module vout_supervisor_tb_top;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [10:0] fb_mv = '0;
  logic        fb_valid = 1'b0;
  logic        ss_done = 1'b0;
  logic        dis = 1'b0;
  logic        fb_ready, pgood, ov_flt, uv_flt, hs_en, ls_en, ls_force;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference state
  int m_win = 0, m_ov = 0, m_uv = 0, m_cb = 0, m_cnt = 0;

  always #5 clk = ~clk;

  vout_supervisor #(.QUAL_CYC(Q)) dut_i (
    .clk(clk), .por_n(por_n), .fb_mv(fb_mv), .fb_valid(fb_valid),
    .fb_ready(fb_ready), .ss_done(ss_done), .dis(dis), .pgood(pgood),
    .ov_flt(ov_flt), .uv_flt(uv_flt), .hs_en(hs_en), .ls_en(ls_en),
    .ls_force(ls_force)
  );

  task automatic cmp1(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int ok_now();
    return (m_win && ss_done && !dis && !m_ov && !m_uv) ? 1 : 0;
  endfunction

  task automatic compare_all();
    logic e_hs, e_ls, e_lf;
    if (!por_n) begin
      e_hs = 1'b0; e_ls = 1'b0; e_lf = 1'b0;
      cmp1("pgood", pgood, 1'b0);
      cmp1("ov_flt", ov_flt, 1'b0);
      cmp1("uv_flt", uv_flt, 1'b0);
      cmp1("ls_force", ls_force, 1'b0);
      return;
    end
    if (m_ov != 0) begin
      e_hs = 1'b0; e_ls = (m_cb != 0); e_lf = (m_cb != 0);
    end else if (m_uv != 0 || dis) begin
      e_hs = 1'b0; e_ls = 1'b0; e_lf = 1'b0;
    end else begin
      e_hs = 1'b1; e_ls = 1'b1; e_lf = 1'b0;
    end
    cmp1("fb_ready", fb_ready, 1'b1);
    cmp1("pgood", pgood, (ok_now() != 0) && (m_cnt == Q));
    cmp1("ov_flt", ov_flt, m_ov != 0);
    cmp1("uv_flt", uv_flt, m_uv != 0);
    cmp1("hs_en", hs_en, e_hs);
    cmp1("ls_en", ls_en, e_ls);
    cmp1("ls_force", ls_force, e_lf);
  endtask

  task automatic model_edge();
    int v;
    if (!por_n) begin
      m_win = 0; m_ov = 0; m_uv = 0; m_cb = 0; m_cnt = 0;
      return;
    end
    v = int'(fb_mv);
    if (ok_now() == 0) m_cnt = 0;
    else if (m_cnt < Q) m_cnt++;
    if (fb_valid) begin
      if (m_win != 0) m_win = (v > 880 || v < 720) ? 0 : 1;
      else            m_win = (v >= 736 && v <= 864) ? 1 : 0;
      if (v > 1000) begin m_ov = 1; m_cb = 1; end
      else if (v < 400) m_cb = 0;
    end
    if (dis) m_uv = 0;
    else if (fb_valid && ss_done && v < 600) m_uv = 1;
  endtask

  // drive on falling edge, compare, then follow the rising edge
  task automatic tick(int fb, bit v, bit ss, bit d, int n = 1);
    for (int i = 0; i < n; i++) begin
      fb_mv = 11'(fb); fb_valid = v; ss_done = ss; dis = d;
      #1;
      compare_all();
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1";  tick(800, 1, 1, 0, 3);
    por_n = 1'b1;
    tag = "R13"; tick(800, 0, 0, 0, 1);
    tag = "R5";  tick(800, 1, 0, 0, 10);
    tag = "R4";  tick(800, 1, 1, 0, Q + 4);
    tag = "R5";  tick(800, 1, 1, 1, 2);
    tag = "R4";  tick(800, 1, 1, 0, Q + 3);
    tag = "R12"; tick(1500, 0, 1, 0, 3);
                 tick(100, 0, 1, 0, 3);
    tag = "R2";  tick(880, 1, 1, 0, 2);
                 tick(720, 1, 1, 0, 2);
                 tick(881, 1, 1, 0, 2);
    tag = "R3";  tick(870, 1, 1, 0, 3);
                 tick(865, 1, 1, 0, 2);
                 tick(864, 1, 1, 0, Q + 3);
    tag = "R2";  tick(719, 1, 1, 0, 2);
    tag = "R3";  tick(735, 1, 1, 0, 2);
                 tick(736, 1, 1, 0, Q + 3);
    tag = "R8";  tick(550, 1, 0, 0, 3);
                 tick(800, 1, 1, 0, Q + 3);
                 tick(599, 1, 1, 1, 2);
                 tick(600, 1, 1, 0, 2);
                 tick(599, 1, 1, 0, 2);
    tag = "R9";  tick(800, 1, 1, 0, 4);
    tag = "R10"; tick(800, 1, 1, 1, 1);
                 tick(800, 1, 1, 0, Q + 3);
                 tick(800, 1, 1, 1, 3);
                 tick(800, 1, 1, 0, Q + 2);
    tag = "R6";  tick(1000, 1, 1, 0, 2);
                 tick(1001, 1, 1, 0, 2);
    tag = "R7";  tick(500, 1, 1, 0, 2);
                 tick(400, 1, 1, 0, 2);
                 tick(399, 1, 1, 0, 2);
                 tick(1000, 1, 1, 0, 2);
                 tick(800, 1, 1, 0, 3);
                 tick(1001, 1, 1, 0, 2);
    tag = "R6";  tick(800, 1, 1, 1, 2);
                 tick(800, 1, 1, 0, Q + 2);
    tag = "R11"; tick(550, 1, 1, 0, 2);
                 tick(300, 1, 1, 0, 2);
                 tick(1100, 1, 1, 0, 2);
    tag = "R1";  por_n = 1'b0;
                 tick(800, 1, 1, 0, 2);
                 por_n = 1'b1;
                 tick(800, 1, 1, 0, 1);
    tag = "R4";  tick(800, 1, 1, 0, Q + 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule